// File: doc/BRIEF.md
# Vertical-Blank Sprite List Transfer Engine

This block moves one frame's sprite attribute list from the sprite RAM that the CPU writes into a private buffer that the renderer reads. The transfer runs inside vertical blanking. The CPU arms it by clearing one bit of a control register. The block looks at that bit only at the moment vertical blank begins. When the bit requests a transfer, the sequence has two phases. First it writes zero to every byte of the buffer. Only after that does it copy every byte of sprite RAM into the buffer, at the same address and in ascending order.

Sprite RAM is read through a synchronous port, and read data comes back one cycle after the request. The buffer is written through a simple write port, one byte per cycle. A busy output covers the whole sequence. Another rise of vertical blank while the sequence runs is ignored. So is any later rewrite of the control register. The buffer size is ENTRIES times BYTES_PER_ENTRY bytes.

Top module: `spr_vbl_dma`

## Requirements
- R1: After synchronous reset, busy is low, no buffer write or sprite RAM read is issued, and control register 0 holds 0xFF. A vertical-blank rise with no control write after reset therefore starts nothing.
- R2: Control register 0 is written when cpu_wr_en is high and cpu_wr_idx is 0. Its bit 4 is the arm bit, and it is active low: 0 requests a transfer. The other seven bits of register 0 have no effect. Writes to any nonzero index have no effect.
- R3: The arm bit is sampled only in the cycle where vblank is first seen high after being low. Arming while vblank is already high starts nothing until the next low-to-high transition.
- R4: Once started, the block writes 0x00 to every buffer address, from 0 to DEPTH-1 in ascending order, one write per cycle. It issues no sprite RAM read until the last clear write is in progress.
- R5: After the clear phase, for each address a from 0 to DEPTH-1 in ascending order, the byte read from sprite RAM address a is written to buffer address a. Each write occurs exactly one cycle after its read request.
- R6: Each copy issues exactly one read per address, and reads appear only while busy is high.
- R7: If the arm bit is 1 at the vertical-blank rise, busy stays low, no write occurs, and the buffer keeps its previous contents.
- R8: busy rises in the cycle after the arming edge. It stays high for exactly 2*DEPTH+1 cycles and falls after the cycle that carries the last copy write. A transfer makes exactly 2*DEPTH buffer writes.
- R9: While busy is high, a new vertical-blank rise and any rewrite of control register 0 neither restart nor abort the running transfer. A transfer also does not repeat once it has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU control register write strobe |
| cpu_wr_idx | input | REG_AW | Control register index |
| cpu_wr_data | input | 8 | Control register write data |
| vblank | input | 1 | Vertical blank level |
| sram_rd_en | output | 1 | Sprite RAM read request |
| sram_rd_addr | output | AW | Sprite RAM byte address |
| sram_rd_data | input | 8 | Sprite RAM read data, valid one cycle after the request |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | AW | Buffer byte address |
| buf_wr_data | output | 8 | Buffer write data |
| busy | output | 1 | Transfer sequence in progress |

## Verification
The hardest case to reach is the one where the transfer must resist disturbance. In that case a fresh vertical-blank rise and a disarming control write both land in the middle of a running sequence. The bench gets there by arming, raising vblank, and then, partway through the clear phase, writing 0xFF to register 0 and toggling vblank low and high again. It then counts the busy cycles and every buffer write to confirm that there was exactly one sequence. It also sweeps all 256 values of register 0 so that the arm bit's position and polarity are pinned down. It raises vblank while already high after arming to show that only the edge samples the bit.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_COPY  = 2'd2,
        ST_DRAIN = 2'd3
    } dma_state_e;

    typedef struct packed {
        logic vld;
        logic from_src;
    } wr_stage_t;

    localparam logic [7:0] CTRL_RESET_VAL = 8'hFF;
    localparam int         ARM_BIT        = 4;

    function automatic logic arm_requested(input logic arm_n);
        return !arm_n;
    endfunction

endpackage

// File: rtl/spr_dma_ctrl_reg.sv
module spr_dma_ctrl_reg
    import spr_dma_pkg::*;
#(
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    output logic              arm_n
);

    logic [7:0] ctrl0_q;
    logic       unused_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0_q <= CTRL_RESET_VAL;
        end else if (wr_en && (wr_idx == '0)) begin
            ctrl0_q <= wr_data;
        end
    end

    assign arm_n       = ctrl0_q[ARM_BIT];
    assign unused_ctrl = ^ctrl0_q;

endmodule

// File: rtl/spr_dma_vbl_edge.sv
module spr_dma_vbl_edge (
    input  logic clk,
    input  logic rst,
    input  logic vblank,
    output logic rise
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= vblank;
        end
    end

    assign rise = vblank && !prev_q;

endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
    import spr_dma_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output wr_stage_t     wr_stage,
    output logic [AW-1:0] wr_addr
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    dma_state_e    state_q;
    logic [AW-1:0] cnt_q;
    wr_stage_t     stage_q;
    logic [AW-1:0] stage_addr_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            stage_q      <= '0;
            stage_addr_q <= '0;
        end else begin
            stage_q.vld      <= (state_q == ST_CLEAR) || (state_q == ST_COPY);
            stage_q.from_src <= (state_q == ST_COPY);
            stage_addr_q     <= cnt_q;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_CLEAR;
                        cnt_q   <= '0;
                    end
                end
                ST_CLEAR: begin
                    if (at_last) begin
                        state_q <= ST_COPY;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_COPY: begin
                    if (at_last) begin
                        state_q <= ST_DRAIN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign rd_en    = (state_q == ST_COPY);
    assign rd_addr  = cnt_q;
    assign wr_stage = stage_q;
    assign wr_addr  = stage_addr_q;

endmodule

// File: rtl/spr_vbl_dma.sv
module spr_vbl_dma
    import spr_dma_pkg::*;
#(
    parameter int ENTRIES         = 128,
    parameter int BYTES_PER_ENTRY = 8,
    parameter int REG_AW          = 3,
    localparam int DEPTH          = ENTRIES * BYTES_PER_ENTRY,
    localparam int AW             = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_en,
    input  logic [REG_AW-1:0] cpu_wr_idx,
    input  logic [7:0]        cpu_wr_data,
    input  logic              vblank,
    output logic              sram_rd_en,
    output logic [AW-1:0]     sram_rd_addr,
    input  logic [7:0]        sram_rd_data,
    output logic              buf_wr_en,
    output logic [AW-1:0]     buf_wr_addr,
    output logic [7:0]        buf_wr_data,
    output logic              busy
);

    logic      ctl_arm_n;
    logic      vbl_rise;
    logic      seq_start;
    wr_stage_t stage;

    spr_dma_ctrl_reg #(
        .REG_AW (REG_AW)
    ) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cpu_wr_en),
        .wr_idx  (cpu_wr_idx),
        .wr_data (cpu_wr_data),
        .arm_n   (ctl_arm_n)
    );

    spr_dma_vbl_edge i_edge (
        .clk    (clk),
        .rst    (rst),
        .vblank (vblank),
        .rise   (vbl_rise)
    );

    assign seq_start = vbl_rise && arm_requested(ctl_arm_n);

    spr_dma_seq #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .busy     (busy),
        .rd_en    (sram_rd_en),
        .rd_addr  (sram_rd_addr),
        .wr_stage (stage),
        .wr_addr  (buf_wr_addr)
    );

    assign buf_wr_en   = stage.vld;
    assign buf_wr_data = stage.from_src ? sram_rd_data : 8'h00;

endmodule

// File: rtl/spr_vbl_dma_chk.sv
module spr_vbl_dma_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          vblank,
    input logic          arm_n,
    input logic          busy,
    input logic          sram_rd_en,
    input logic [AW-1:0] sram_rd_addr,
    input logic          buf_wr_en,
    input logic [AW-1:0] buf_wr_addr
);

    logic vbl_prev_q;

    always_ff @(posedge clk) begin
        if (rst) vbl_prev_q <= 1'b0;
        else     vbl_prev_q <= vblank;
    end

    AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> busy);                                            // R8
    AST_READ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        sram_rd_en |-> busy);                                           // R6
    AST_NO_READ_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !sram_rd_en);                                   // R4
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        sram_rd_en |=> (buf_wr_en && buf_wr_addr == $past(sram_rd_addr))); // R5
    AST_ARMED_EDGE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (vblank && !vbl_prev_q && !busy && !arm_n) |=> busy);           // R3
    AST_DISARMED_EDGE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (vblank && !vbl_prev_q && !busy && arm_n) |=> !busy);           // R7

endmodule

bind spr_vbl_dma spr_vbl_dma_chk #(.AW(AW)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .vblank       (vblank),
    .arm_n        (ctl_arm_n),
    .busy         (busy),
    .sram_rd_en   (sram_rd_en),
    .sram_rd_addr (sram_rd_addr),
    .buf_wr_en    (buf_wr_en),
    .buf_wr_addr  (buf_wr_addr)
);

// File: tb/test_spr_vbl_dma.sv
module test_spr_vbl_dma;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 4;
    localparam int BPE        = 2;
    localparam int REG_AW     = 3;
    localparam int DEPTH      = ENTRIES * BPE;
    localparam int AW         = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_wr_en = 1'b0;
    logic [REG_AW-1:0] cpu_wr_idx = '0;
    logic [7:0]        cpu_wr_data = '0;
    logic              vblank = 1'b0;
    logic              sram_rd_en;
    logic [AW-1:0]     sram_rd_addr;
    logic [7:0]        sram_rd_data = '0;
    logic              buf_wr_en;
    logic [AW-1:0]     buf_wr_addr;
    logic [7:0]        buf_wr_data;
    logic              busy;

    int   checks = 0;
    int   errors = 0;
    int   wcnt = 0;
    int   rcnt = 0;
    int   busy_cyc = 0;
    int   cur_seed = 0;
    int   last_seed = 0;
    bit   filled = 1'b0;
    bit   exp_xfer = 1'b0;
    logic [7:0] bufm [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_vbl_dma #(
        .ENTRIES         (ENTRIES),
        .BYTES_PER_ENTRY (BPE),
        .REG_AW          (REG_AW)
    ) i_spr_vbl_dma (
        .clk          (clk),
        .rst          (rst),
        .cpu_wr_en    (cpu_wr_en),
        .cpu_wr_idx   (cpu_wr_idx),
        .cpu_wr_data  (cpu_wr_data),
        .vblank       (vblank),
        .sram_rd_en   (sram_rd_en),
        .sram_rd_addr (sram_rd_addr),
        .sram_rd_data (sram_rd_data),
        .buf_wr_en    (buf_wr_en),
        .buf_wr_addr  (buf_wr_addr),
        .buf_wr_data  (buf_wr_data),
        .busy         (busy)
    );

    function automatic logic [7:0] src_byte(input int seed, input int a);
        return 8'((a * 29) + (seed * 7) + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Sprite RAM model: registered read, one cycle latency
    always @(posedge clk) begin
        if (sram_rd_en) sram_rd_data <= src_byte(cur_seed, int'(sram_rd_addr));
    end

    // Port monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cyc++;
            if (sram_rd_en) begin
                chk(exp_xfer, "R6", "read outside transfer", 1, 0);
                chk(int'(sram_rd_addr) == rcnt, "R6", "read address", int'(sram_rd_addr), rcnt);
                chk(wcnt >= DEPTH - 1, "R4", "read before clear done", wcnt, DEPTH - 1);
                rcnt++;
            end
            if (buf_wr_en) begin
                if (!exp_xfer || wcnt >= 2 * DEPTH) begin
                    chk(1'b0, "R7", "unexpected buffer write", wcnt, 2 * DEPTH);
                end else if (wcnt < DEPTH) begin
                    chk(int'(buf_wr_addr) == wcnt, "R4", "clear address", int'(buf_wr_addr), wcnt);
                    chk(buf_wr_data == 8'h00, "R4", "clear data", int'(buf_wr_data), 0);
                end else begin
                    chk(int'(buf_wr_addr) == wcnt - DEPTH, "R5", "copy address",
                        int'(buf_wr_addr), wcnt - DEPTH);
                    chk(buf_wr_data == src_byte(cur_seed, wcnt - DEPTH), "R5", "copy data",
                        int'(buf_wr_data), int'(src_byte(cur_seed, wcnt - DEPTH)));
                end
                bufm[buf_wr_addr] = buf_wr_data;
                wcnt++;
            end
        end
    end

    task automatic cpu_write(input int idx, input int data);
        @(negedge clk);
        cpu_wr_en   = 1'b1;
        cpu_wr_idx  = REG_AW'(idx);
        cpu_wr_data = 8'(data);
        @(negedge clk);
        cpu_wr_en   = 1'b0;
    endtask

    task automatic vbl_low();
        @(negedge clk);
        vblank = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        @(negedge clk);
        while (busy && t < 4 * DEPTH) begin
            @(negedge clk);
            t++;
        end
        chk(wcnt == 2 * DEPTH, req, "write count", wcnt, 2 * DEPTH);
        chk(busy_cyc == 2 * DEPTH + 1, "R8", "busy cycles", busy_cyc, 2 * DEPTH + 1);
        chk(rcnt == DEPTH, "R6", "read count", rcnt, DEPTH);
        last_seed = cur_seed;
        filled = 1'b1;
    endtask

    task automatic check_quiet(input string req);
        repeat (2 * DEPTH + 4) @(negedge clk);
        chk(busy_cyc == 0, req, "busy cycles when idle", busy_cyc, 0);
        chk(wcnt == 0, req, "writes when idle", wcnt, 0);
        if (filled) begin
            for (int a = 0; a < DEPTH; a++) begin
                chk(bufm[a] == src_byte(last_seed, a), req, "buffer kept",
                    int'(bufm[a]), int'(src_byte(last_seed, a)));
            end
        end
    endtask

    task automatic edge_xfer(input bit go, input string req);
        wcnt = 0; rcnt = 0; busy_cyc = 0; exp_xfer = go;
        @(negedge clk);
        vblank = 1'b1;
        if (go) wait_done(req);
        else    check_quiet(req);
        exp_xfer = 1'b0;
    endtask

    initial begin
        repeat (1000 * DEPTH) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) bufm[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(buf_wr_en == 1'b0, "R1", "write after reset", int'(buf_wr_en), 0);
        chk(sram_rd_en == 1'b0, "R1", "read after reset", int'(sram_rd_en), 0);
        // R1: control register resets disarmed
        edge_xfer(1'b0, "R1");
        vbl_low();

        // R2: sweep every value of register 0; only bit 4 low arms
        for (int v = 0; v < 256; v++) begin
            cur_seed = v;
            cpu_write(0, v);
            edge_xfer(((v >> 4) & 1) == 0, "R2");
            vbl_low();
        end

        // R2: nonzero register indices do not arm
        cpu_write(0, 8'hFF);
        for (int k = 1; k < (1 << REG_AW); k++) begin
            cpu_write(k, 8'h00);
            edge_xfer(1'b0, "R2");
            vbl_low();
        end

        // R3: arming while vblank already high starts nothing until next rise
        cur_seed = 300;
        cpu_write(0, 8'hFF);
        edge_xfer(1'b0, "R3");
        cpu_write(0, 8'h00);
        wcnt = 0; busy_cyc = 0;
        check_quiet("R3");
        vbl_low();
        edge_xfer(1'b1, "R3");
        vbl_low();

        // R7: disarmed edge keeps buffer contents
        cpu_write(0, 8'h10);
        edge_xfer(1'b0, "R7");
        vbl_low();

        // R9: disturbances during a running transfer
        cur_seed = 411;
        cpu_write(0, 8'hEF);
        wcnt = 0; rcnt = 0; busy_cyc = 0; exp_xfer = 1'b1;
        @(negedge clk);
        vblank = 1'b1;
        repeat (2) @(negedge clk);
        cpu_write(0, 8'hFF);
        vblank = 1'b0;
        @(negedge clk);
        vblank = 1'b1;
        cpu_write(0, 8'h00);
        wait_done("R9");
        repeat (2 * DEPTH + 4) @(negedge clk);
        chk(wcnt == 2 * DEPTH, "R9", "no repeat after finish", wcnt, 2 * DEPTH);
        chk(busy_cyc == 2 * DEPTH + 1, "R9", "single busy window", busy_cyc, 2 * DEPTH + 1);
        exp_xfer = 1'b0;
        vbl_low();

        // R1: synchronous reset restores the disarmed register
        cpu_write(0, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        filled = 1'b0;
        edge_xfer(1'b0, "R1");
        vbl_low();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule